// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Picture Buffer

This block carries decoded picture samples from a system clock domain, where a decoder and external memory live, to a display clock domain that drives a screen. Two buffer banks alternate. While the display side drains one bank, the system side refills the other from memory. Each bank holds a luma RAM and a chroma RAM, so four dual-port RAMs sit between the domains. The only signals that cross the clock boundary are two per-bank level flags: "bank filled" going to the display side, and "bank shown" coming back. Each passes through a two-flop synchronizer.

On the system side, a host pulses `start_disp` to begin moving a frame and `end_disp` to stop. The block walks the frame in bank-sized blocks. It raises `mem_req` with a frame word offset on `mem_addr`, and takes a luma/chroma pair each cycle in which memory answers with `mem_ack`. After the last word of a frame it pulses `frame_done`, so the host can point memory at the next picture. On the display side, each `pix_req` returns one pixel pair a cycle later. When no filled bank is waiting, `pix_empty` is high and the block returns black.

Top module: `pp_frame_xfer`

## Requirements
- R1: While both resets are held low and after their release, `mem_req` and `frame_done` are 0, `pix_empty` is 1 and `pix_vld` is 0.
- R2: `mem_req` stays 0 until `start_disp` has been pulsed high for one system cycle.
- R3: `mem_addr` equals block index times BANK_WORDS plus word index, beginning at 0. It advances by one after each system cycle in which `mem_req` and `mem_ack` are both 1, and holds otherwise. It wraps to 0 after BANK_WORDS*BLOCKS-1.
- R4: Every word accepted into a bank that completes is delivered exactly once and in acceptance order. A `pix_req` sampled while `pix_empty` is 0 yields `pix_vld`=1 with that word on `pix_luma`/`pix_chroma` in the next display cycle.
- R5: A `pix_req` sampled while `pix_empty` is 1 yields, in the next display cycle, `pix_vld`=0 with black (`pix_luma`=16, `pix_chroma`=128). It consumes no word.
- R6: With the display idle, exactly 2*BANK_WORDS words are accepted, and then `mem_req` stays 0. No bank is overwritten before it is shown.
- R7: A bank is refilled only after the display has read every word of it. Release uses a four-phase level handshake: the filled flag stays high until the synchronized shown flag is high, and both return low before the bank is used again.
- R8: `frame_done` is a one-system-cycle pulse in the cycle after the word at offset BANK_WORDS*BLOCKS-1 is accepted.
- R9: From the cycle after `end_disp`, `mem_req` is 0. A beat offered in the same cycle as `end_disp` is not taken. The partly filled bank is discarded, and the next `start_disp` restarts at offset 0. When `start_disp` and `end_disp` are high together, `end_disp` wins.
- R10: Luma and chroma travel in separate RAMs per bank. Each delivered pair holds the luma and chroma values that were accepted in the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| start_disp | input | 1 | Pulse: enable frame transfer |
| end_disp | input | 1 | Pulse: stop transfer and rewind frame position |
| frame_done | output | 1 | Pulse after the last word of a frame is accepted |
| mem_req | output | 1 | Request for the word at `mem_addr` |
| mem_addr | output | $clog2(BANK_WORDS*BLOCKS) | Word offset within the frame |
| mem_ack | input | 1 | Memory supplies data this cycle |
| mem_luma | input | YW | Luma sample from memory |
| mem_chroma | input | CW | Chroma sample from memory |
| disp_clk | input | 1 | Display clock |
| disp_rst_n | input | 1 | Synchronous active-low reset, display domain |
| pix_req | input | 1 | Display asks for the next pixel pair |
| pix_empty | output | 1 | No filled bank is ready to read |
| pix_vld | output | 1 | Pixel outputs carry buffered data |
| pix_luma | output | YW | Luma out, black when not valid |
| pix_chroma | output | CW | Chroma out, black when not valid |

## Verification
The cross-domain assertions assume that both resets are applied together and released before the first start command. They also assume that `start_disp` and `end_disp` are single-cycle pulses and that BANK_WORDS is at least 2, so that two frame-done pulses can never touch. The bench asserts both resets from one signal, drives commands for exactly one cycle, and runs the two clocks at 10 and 8 time units with offset phases so their falling edges never meet. Memory acknowledges and display requests come from a seeded random source, mixed with directed phases: display held idle, drained one word short of a bank, and stop commands issued mid-bank and together with start.

// File: rtl/pp_pkg.sv
// Shared definitions for the ping-pong picture buffer.
// Assumes exactly two banks; bank identity is a single bit.
package pp_pkg;
    localparam int NUM_BANKS = 2;

    // One flag per bank, bit index = bank number.
    typedef logic [NUM_BANKS-1:0] bank_mask_t;

    // The bank that is not the given one.
    function automatic logic other_bank(input logic b);
        return ~b;
    endfunction
endpackage

// File: rtl/pp_sync2.sv
// Two-stage synchronizer for level signals entering a clock domain.
// Assumes each bit is an independent, glitch-free level from a register
// in the source domain; no bus coherence is offered.
module pp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then re-register the incoming level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pp_dpram.sv
// Behavioural simple dual-port RAM with independent write and read clocks.
// Assumes the controller never reads and writes one address in the same
// period; read data is registered (one read-clock latency).
module pp_dpram #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port, system side.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port, display side.
    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pp_fill_ctrl.sv
// System-side filler: walks a frame in bank-sized blocks, requests words
// from memory and writes them into the free bank. It raises a per-bank
// "filled" level and drops it once the synchronized "shown" level is seen.
// Assumes start/end commands are one-cycle pulses and BANK_WORDS >= 2.
module pp_fill_ctrl
    import pp_pkg::*;
#(
    parameter int BANK_WORDS = 16,
    parameter int BLOCKS     = 4,
    localparam int AW        = $clog2(BANK_WORDS),
    localparam int BLKW      = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int FAW       = $clog2(BANK_WORDS * BLOCKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_disp,
    input  logic           end_disp,
    input  logic           mem_ack,
    input  bank_mask_t     shown_s,
    output logic           mem_req,
    output logic [FAW-1:0] mem_addr,
    output logic           frame_done,
    output bank_mask_t     filled,
    output logic           ram_we,
    output logic           ram_bank,
    output logic [AW-1:0]  ram_addr
);
    logic            active;
    logic            wr_bank;
    logic [AW-1:0]   wr_ptr;
    logic [BLKW-1:0] blk_idx;
    logic            beat;
    logic            last_word;

    // Current bank may be written only when free on both sides.
    assign mem_req   = active && !filled[wr_bank] && !shown_s[wr_bank];
    assign beat      = mem_req && mem_ack && !end_disp;
    assign last_word = (wr_ptr == AW'(BANK_WORDS - 1));
    assign ram_we    = beat;
    assign ram_bank  = wr_bank;
    assign ram_addr  = wr_ptr;

    // Frame word offset presented to memory.
    always_comb begin
        mem_addr = FAW'(int'(blk_idx) * BANK_WORDS + int'(wr_ptr));
    end

    // Enable, frame position and frame-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            wr_bank    <= 1'b0;
            wr_ptr     <= '0;
            blk_idx    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (end_disp) begin
                active  <= 1'b0;
                wr_ptr  <= '0;
                blk_idx <= '0;
            end else if (start_disp) begin
                active <= 1'b1;
            end
            if (beat) begin
                if (last_word) begin
                    wr_ptr  <= '0;
                    wr_bank <= other_bank(wr_bank);
                    if (blk_idx == BLKW'(BLOCKS - 1)) begin
                        blk_idx    <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        blk_idx <= blk_idx + 1'b1;
                    end
                end else begin
                    wr_ptr <= wr_ptr + 1'b1;
                end
            end
        end
    end

    // Per-bank filled level: set on the last write, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (beat && last_word && (wr_bank == 1'(b)))
                    filled[b] <= 1'b1;
                else if (filled[b] && shown_s[b])
                    filled[b] <= 1'b0;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fill_chk
        AST_FILLED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(filled[b]) |-> $past(shown_s[b])); // R7
    end

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(end_disp) |-> !mem_req); // R9
endmodule

// File: rtl/pp_drain_ctrl.sv
// Display-side drainer: reads the ready bank word by word on request,
// raises a per-bank "shown" level after its last word, and drops it once
// the synchronized "filled" level has gone low.
// Assumes the filler never writes a bank whose shown level is high.
module pp_drain_ctrl
    import pp_pkg::*;
#(
    parameter int BANK_WORDS = 16,
    localparam int AW        = $clog2(BANK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_req,
    input  bank_mask_t    filled_s,
    output logic          pix_empty,
    output bank_mask_t    shown,
    output logic          rd_en,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          out_vld,
    output logic          out_bank
);
    logic          ready;
    logic [AW-1:0] rd_ptr;
    logic          last_word;

    // A bank is readable while filled and not yet marked shown.
    assign ready     = filled_s[rd_bank] && !shown[rd_bank];
    assign pix_empty = !ready;
    assign rd_en     = pix_req && ready;
    assign rd_addr   = rd_ptr;
    assign last_word = (rd_ptr == AW'(BANK_WORDS - 1));

    // Read pointer, bank selection and output-valid pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bank  <= 1'b0;
            rd_ptr   <= '0;
            out_vld  <= 1'b0;
            out_bank <= 1'b0;
        end else begin
            out_vld  <= rd_en;
            out_bank <= rd_bank;
            if (rd_en) begin
                if (last_word) begin
                    rd_ptr  <= '0;
                    rd_bank <= other_bank(rd_bank);
                end else begin
                    rd_ptr <= rd_ptr + 1'b1;
                end
            end
        end
    end

    // Per-bank shown level: set after the last read, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shown <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (rd_en && last_word && (rd_bank == 1'(b)))
                    shown[b] <= 1'b1;
                else if (shown[b] && !filled_s[b])
                    shown[b] <= 1'b0;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_drain_chk
        AST_SHOWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(shown[b]) |-> !$past(filled_s[b])); // R7
    end
endmodule

// File: rtl/pp_frame_xfer.sv
// Top: dual-clock ping-pong picture buffer. Two banks, each with a luma
// and a chroma RAM, are filled on the system clock and drained on the
// display clock. Only the per-bank filled/shown levels cross, each through
// a two-flop synchronizer. Assumes both resets are applied together.
module pp_frame_xfer
    import pp_pkg::*;
#(
    parameter int BANK_WORDS = 16,
    parameter int BLOCKS     = 4,
    parameter int YW         = 8,
    parameter int CW         = 8,
    parameter int BLACK_Y    = 16,
    parameter int BLACK_C    = 128,
    localparam int AW        = $clog2(BANK_WORDS),
    localparam int FAW       = $clog2(BANK_WORDS * BLOCKS)
) (
    input  logic           sys_clk,
    input  logic           sys_rst_n,
    input  logic           start_disp,
    input  logic           end_disp,
    output logic           frame_done,
    output logic           mem_req,
    output logic [FAW-1:0] mem_addr,
    input  logic           mem_ack,
    input  logic [YW-1:0]  mem_luma,
    input  logic [CW-1:0]  mem_chroma,
    input  logic           disp_clk,
    input  logic           disp_rst_n,
    input  logic           pix_req,
    output logic           pix_empty,
    output logic           pix_vld,
    output logic [YW-1:0]  pix_luma,
    output logic [CW-1:0]  pix_chroma
);
    bank_mask_t    filled, filled_s, shown, shown_s;
    logic          ram_we, ram_bank;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic          rd_en, rd_bank, out_vld, out_bank;
    logic [YW-1:0] luma_q   [NUM_BANKS];
    logic [CW-1:0] chroma_q [NUM_BANKS];

    pp_fill_ctrl #(.BANK_WORDS(BANK_WORDS), .BLOCKS(BLOCKS)) u_fill (
        .clk        (sys_clk),
        .rst_n      (sys_rst_n),
        .start_disp (start_disp),
        .end_disp   (end_disp),
        .mem_ack    (mem_ack),
        .shown_s    (shown_s),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .frame_done (frame_done),
        .filled     (filled),
        .ram_we     (ram_we),
        .ram_bank   (ram_bank),
        .ram_addr   (ram_waddr)
    );

    pp_sync2 #(.W(NUM_BANKS)) u_sync_to_disp (
        .clk (disp_clk), .rst_n (disp_rst_n), .d (filled), .q (filled_s)
    );

    pp_sync2 #(.W(NUM_BANKS)) u_sync_to_sys (
        .clk (sys_clk), .rst_n (sys_rst_n), .d (shown), .q (shown_s)
    );

    pp_drain_ctrl #(.BANK_WORDS(BANK_WORDS)) u_drain (
        .clk       (disp_clk),
        .rst_n     (disp_rst_n),
        .pix_req   (pix_req),
        .filled_s  (filled_s),
        .pix_empty (pix_empty),
        .shown     (shown),
        .rd_en     (rd_en),
        .rd_bank   (rd_bank),
        .rd_addr   (ram_raddr),
        .out_vld   (out_vld),
        .out_bank  (out_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = ram_we && (ram_bank == 1'(b));

        pp_dpram #(.DW(YW), .DEPTH(BANK_WORDS)) u_luma (
            .wclk (sys_clk), .we (bank_we), .waddr (ram_waddr), .wdata (mem_luma),
            .rclk (disp_clk), .raddr (ram_raddr), .rdata (luma_q[b])
        );

        pp_dpram #(.DW(CW), .DEPTH(BANK_WORDS)) u_chroma (
            .wclk (sys_clk), .we (bank_we), .waddr (ram_waddr), .wdata (mem_chroma),
            .rclk (disp_clk), .raddr (ram_raddr), .rdata (chroma_q[b])
        );
    end

    // Output select: buffered data when valid, black otherwise.
    assign pix_vld    = out_vld;
    assign pix_luma   = out_vld ? luma_q[out_bank]   : YW'(BLACK_Y);
    assign pix_chroma = out_vld ? chroma_q[out_bank] : CW'(BLACK_C);

    AST_READ_FILLED: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
        rd_en |-> filled[rd_bank]); // R7

    AST_WRITE_UNSHOWN: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ram_we |-> !shown[ram_bank]); // R6
endmodule

// File: tb/tb_pp_frame_xfer.sv
// Self-checking bench: seeded random memory acknowledges and display
// requests, plus directed phases for overrun, release order and stop.
module tb_pp_frame_xfer;
    localparam int BW    = 16;
    localparam int NBLK  = 4;
    localparam int FRAME = BW * NBLK;

    logic       sys_clk = 0, disp_clk = 0, rst_n = 0;
    logic       start_disp = 0, end_disp = 0, mem_ack = 0, pix_req = 0;
    logic [7:0] mem_luma = 0, mem_chroma = 0;
    logic       frame_done, mem_req, pix_empty, pix_vld;
    logic [5:0] mem_addr;
    logic [7:0] pix_luma, pix_chroma;

    int n_chk = 0, n_fail = 0;
    int exp_off = 0, frame_no = 0, part = 0, acc_cnt = 0, fd_seen = 0;
    bit fd_exp = 0, finished = 0;
    int ack_mode = 0, rd_mode = 0, rd_budget = 0;
    logic [15:0] exp_q[$];

    pp_frame_xfer #(.BANK_WORDS(BW), .BLOCKS(NBLK)) dut (
        .sys_clk(sys_clk), .sys_rst_n(rst_n), .start_disp(start_disp),
        .end_disp(end_disp), .frame_done(frame_done), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_luma(mem_luma),
        .mem_chroma(mem_chroma), .disp_clk(disp_clk), .disp_rst_n(rst_n),
        .pix_req(pix_req), .pix_empty(pix_empty), .pix_vld(pix_vld),
        .pix_luma(pix_luma), .pix_chroma(pix_chroma)
    );

    initial forever #5 sys_clk = ~sys_clk;
    initial begin #1; forever #4 disp_clk = ~disp_clk; end

    function automatic logic [7:0] y_of(input int off, input int fr);
        return 8'(off * 7 + fr * 29 + 3);
    endfunction

    function automatic logic [7:0] c_of(input int off, input int fr);
        return 8'((off * 11) ^ (fr * 5) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One system cycle: check last frame pulse, drive inputs, model accept.
    task automatic sys_cycle(input bit st, input bit en);
        @(negedge sys_clk);
        if (frame_done || fd_exp) chk(frame_done == fd_exp, "R8", frame_done, fd_exp);
        if (frame_done) fd_seen++;
        fd_exp = 0;
        start_disp = st;
        end_disp   = en;
        case (ack_mode)
            1:       mem_ack = 1'b1;
            2:       mem_ack = ($urandom_range(0, 3) != 0);
            default: mem_ack = 1'b0;
        endcase
        mem_luma   = y_of(exp_off, frame_no);
        mem_chroma = c_of(exp_off, frame_no);
        if (en) begin
            repeat (part) void'(exp_q.pop_back());
            part    = 0;
            exp_off = 0;
        end else if (mem_req && mem_ack) begin
            chk(int'(mem_addr) == exp_off, "R3", mem_addr, exp_off);
            exp_q.push_back({mem_luma, mem_chroma});
            acc_cnt++;
            part = (part == BW - 1) ? 0 : part + 1;
            if (exp_off == FRAME - 1) begin
                exp_off = 0;
                fd_exp  = 1;
                frame_no++;
            end else begin
                exp_off++;
            end
        end
    endtask

    // Display side driver and checker.
    initial begin
        bit pend_req = 0, pend_rdy = 0, req;
        logic [15:0] e;
        forever begin
            @(negedge disp_clk);
            if (!rst_n) begin
                pend_req = 0;
                pix_req  = 0;
            end else begin
                if (pend_req) begin
                    if (pend_rdy) begin
                        if (exp_q.size() == 0) begin
                            chk(0, "R4", pix_vld, 0);
                        end else begin
                            e = exp_q.pop_front();
                            chk(pix_vld === 1'b1, "R4", pix_vld, 1);
                            chk(pix_luma === e[15:8], "R4", pix_luma, e[15:8]);
                            chk(pix_chroma === e[7:0], "R10", pix_chroma, e[7:0]);
                        end
                    end else begin
                        chk(pix_vld === 1'b0 && pix_luma == 8'd16 && pix_chroma == 8'd128,
                            "R5", pix_luma, 16);
                    end
                end
                case (rd_mode)
                    1:       req = ($urandom_range(0, 2) != 0);
                    2:       req = (rd_budget > 0);
                    default: req = 0;
                endcase
                if (rd_mode == 2 && req && !pix_empty) rd_budget--;
                pend_req = req;
                pend_rdy = !pix_empty;
                pix_req  = req;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge sys_clk);
        chk(mem_req == 0 && frame_done == 0, "R1", mem_req, 0);
        rst_n = 1;
        // R1 / R2 / R5: idle after reset, display asking while empty
        ack_mode = 1;
        rd_mode  = 1;
        repeat (20) sys_cycle(0, 0);
        chk(pix_empty == 1, "R1", pix_empty, 1);
        chk(pix_vld == 0, "R1", pix_vld, 0);
        chk(mem_req == 0, "R2", mem_req, 0);
        chk(acc_cnt == 0, "R2", acc_cnt, 0);
        rd_mode = 0;
        repeat (5) sys_cycle(0, 0);
        // R6: display idle, writer must stop after two banks
        sys_cycle(1, 0);
        repeat (100) sys_cycle(0, 0);
        chk(acc_cnt == 2 * BW, "R6", acc_cnt, 2 * BW);
        chk(mem_req == 0, "R6", mem_req, 0);
        // R7: one word short of a bank keeps the writer blocked
        rd_budget = BW - 1;
        rd_mode   = 2;
        repeat (60) sys_cycle(0, 0);
        chk(acc_cnt == 2 * BW, "R7", acc_cnt, 2 * BW);
        rd_budget = 1;
        repeat (60) sys_cycle(0, 0);
        chk(acc_cnt == 3 * BW, "R7", acc_cnt, 3 * BW);
        // Random traffic on both sides
        ack_mode = 2;
        rd_mode  = 1;
        repeat (3000) sys_cycle(0, 0);
        // R9: stop mid-bank, then start together with stop
        sys_cycle(0, 1);
        @(posedge sys_clk); #1;
        chk(mem_req == 0, "R9", mem_req, 0);
        repeat (20) sys_cycle(0, 0);
        chk(mem_req == 0, "R9", mem_req, 0);
        sys_cycle(1, 1);
        @(posedge sys_clk); #1;
        chk(mem_req == 0, "R9", mem_req, 0);
        sys_cycle(1, 0);
        repeat (2000) sys_cycle(0, 0);
        // Drain: stop transfers, display empties all completed banks
        sys_cycle(0, 1);
        repeat (600) sys_cycle(0, 0);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        chk(fd_seen > 0, "R8", fd_seen, 1);
        chk(pix_empty == 1, "R5", pix_empty, 1);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule